// File: doc/BRIEF.md
# Nibble accumulator core

This block is a small 4-bit processor core that completes one instruction on every clock. Each program word is 8 bits wide: an opcode in the upper nibble and an immediate operand in the lower nibble. The core has three 4-bit working registers, X, Y and Z. An 8-bit location pointer addresses a 256-entry nibble data memory. An 8-bit branch target register is filled one nibble at a time, and a conditional jump uses it only when Z is zero. Add and subtract share a carry/borrow flag. A toggle instruction arms a one-shot option that makes the next arithmetic operation also consume that flag.

The program store and the data memory are both arrays inside the wrapper. The program store is filled through a write port, normally while the core is held in reset. Data memory entries 0 to 3 form a 4x4 pixel frame, which the core drives continuously on a 16-bit output, one nibble per row. After reset the core does nothing in its first clock and steps over word 0, so word 0 only runs when the program counter later wraps or jumps to it.

Top module: `nib_core`

## Requirements
- R1: Reset clears the program counter, X, Y, Z, the carry flag, the one-shot carry option, the location pointer and the branch target. In the first clock after reset is released no instruction takes effect and the program counter goes from 0 to 1.
- R2: A program word is {opcode[7:4], imm[3:0]}. The opcodes are NOP=0, ADD=1, SUB=2, LOCHI=3, LOCLO=4, SETX=5, SETY=6, SETZ=7, STZ=8, LDZ=9, TGTHI=10, TGTLO=11, JZ=12, LDX=13, LDY=14, CTGL=15. Every instruction other than a taken jump advances the program counter by one, wrapping from 255 to 0.
- R3: NOP leaves X, Y, Z and the carry flag unchanged.
- R4: SETX, SETY and SETZ load the immediate into X, Y and Z respectively, visible after the clock edge that executes them.
- R5: ADD writes (X+Y) mod 16 into Z and sets the carry flag to the carry out of bit 3.
- R6: SUB writes (X−Y) mod 16 into Z and sets the carry flag to 1 exactly when a borrow occurs.
- R7: CTGL toggles the one-shot carry option. While it is set, the next ADD adds the carry flag and the next SUB subtracts it as a borrow. That ADD or SUB clears the option. Instructions that are not arithmetic leave it as it is, so two CTGL in a row cancel.
- R8: LOCHI and LOCLO load the upper and lower nibble of the 8-bit location pointer. STZ writes Z to the data memory at the pointer. LDZ, LDX and LDY load the addressed data nibble into Z, X or Y. All 8 pointer bits select the entry.
- R9: TGTHI and TGTLO load the upper and lower nibble of the branch target. JZ sets the program counter to the target when Z is 0, and otherwise advances it by one.
- R10: frameOut carries data memory entries 3, 2, 1, 0 from the top nibble down, so row 0 is in bits 3:0.
- R11: A clock edge with loadEn high writes loadWord into the program store at loadAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Program store write enable |
| loadAddr | input | 8 | Program store write address |
| loadWord | input | 8 | Program word to write |
| pcOut | output | 8 | Current program counter |
| xOut | output | 4 | Register X |
| yOut | output | 4 | Register Y |
| zOut | output | 4 | Register Z |
| carryOut | output | 1 | Carry/borrow flag |
| frameOut | output | 16 | Four pixel rows from data entries 0 to 3 |

## Verification
The bench builds the core with the default nibble width of 4, which gives an 8-bit program counter, location pointer and branch target over 256-entry arrays. At that size a jump to a target near the top of the program store reaches the 255-to-0 wrap within a few cycles, and that wrap then executes word 0 for the first time. A data write whose location has a non-zero upper nibble also fits in a short program, and the frame output then shows whether the upper pointer bits are honoured. Carry chains are short enough that add with carry-in, subtract with borrow-in, and a cancelled double toggle can each be told apart by a single Z value.

// File: rtl/nib_pkg.sv
package nib_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_LOCHI = 4'd3,
    OP_LOCLO = 4'd4,
    OP_SETX  = 4'd5,
    OP_SETY  = 4'd6,
    OP_SETZ  = 4'd7,
    OP_STZ   = 4'd8,
    OP_LDZ   = 4'd9,
    OP_TGTHI = 4'd10,
    OP_TGTLO = 4'd11,
    OP_JZ    = 4'd12,
    OP_LDX   = 4'd13,
    OP_LDY   = 4'd14,
    OP_CTGL  = 4'd15
  } opcode_e;

  typedef enum logic [1:0] {
    SRC_IMM = 2'd0,
    SRC_RAM = 2'd1,
    SRC_ALU = 2'd2
  } src_e;

  typedef struct packed {
    logic wrX;
    logic wrY;
    logic wrZ;
    src_e src;
    logic locHi;
    logic locLo;
    logic ramWr;
    logic aluSub;
    logic aluGo;
    logic useTgl;
  } strobe_t;

endpackage

// File: rtl/nib_alu.sv
module nib_alu #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  logic          cin,
  input  logic          doSub,
  output logic [DW-1:0] res,
  output logic          cout
);

  logic [DW:0] wide;
  logic [DW:0] cinExt;

  assign cinExt = {{DW{1'b0}}, cin};

  always_comb begin
    if (doSub) begin
      wide = {1'b0, opA} - {1'b0, opB} - cinExt;
    end else begin
      wide = {1'b0, opA} + {1'b0, opB} + cinExt;
    end
  end

  // top bit is the carry out for add and the borrow for subtract
  assign res  = wide[DW-1:0];
  assign cout = wide[DW];

endmodule

// File: rtl/nib_ctrl.sv
module nib_ctrl
  import nib_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [OP_W+DW-1:0]   instrWord,
  input  logic                 zIsZero,
  output strobe_t              strb,
  output logic [DW-1:0]        imm,
  output logic [2*DW-1:0]      pc
);

  localparam int AW = 2 * DW;
  localparam int IW = OP_W + DW;

  opcode_e       op;
  logic          running;
  logic          takeJump;
  logic [AW-1:0] jmpTgt;

  assign op  = opcode_e'(instrWord[IW-1:DW]);
  assign imm = instrWord[DW-1:0];

  always_comb begin
    strb = '0;
    if (running) begin
      case (op)
        OP_ADD: begin
          strb.wrZ   = 1'b1;
          strb.src   = SRC_ALU;
          strb.aluGo = 1'b1;
        end
        OP_SUB: begin
          strb.wrZ    = 1'b1;
          strb.src    = SRC_ALU;
          strb.aluGo  = 1'b1;
          strb.aluSub = 1'b1;
        end
        OP_LOCHI: strb.locHi = 1'b1;
        OP_LOCLO: strb.locLo = 1'b1;
        OP_SETX: begin
          strb.wrX = 1'b1;
          strb.src = SRC_IMM;
        end
        OP_SETY: begin
          strb.wrY = 1'b1;
          strb.src = SRC_IMM;
        end
        OP_SETZ: begin
          strb.wrZ = 1'b1;
          strb.src = SRC_IMM;
        end
        OP_STZ: strb.ramWr = 1'b1;
        OP_LDZ: begin
          strb.wrZ = 1'b1;
          strb.src = SRC_RAM;
        end
        OP_LDX: begin
          strb.wrX = 1'b1;
          strb.src = SRC_RAM;
        end
        OP_LDY: begin
          strb.wrY = 1'b1;
          strb.src = SRC_RAM;
        end
        OP_CTGL: strb.useTgl = 1'b1;
        default: strb = '0;
      endcase
    end
  end

  assign takeJump = running && (op == OP_JZ) && zIsZero;

  // first cycle after reset: step over word 0 without executing it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      pc      <= '0;
      jmpTgt  <= '0;
    end else begin
      running <= 1'b1;
      if (takeJump) begin
        pc <= jmpTgt;
      end else begin
        pc <= pc + AW'(1);
      end
      if (running && op == OP_TGTHI) begin
        jmpTgt[AW-1:DW] <= imm;
      end
      if (running && op == OP_TGTLO) begin
        jmpTgt[DW-1:0] <= imm;
      end
    end
  end

endmodule

// File: rtl/nib_dpath.sv
module nib_dpath
  import nib_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DW-1:0]     imm,
  input  logic [DW-1:0]     ramRd,
  output logic [2*DW-1:0]   ramAddr,
  output logic              ramWe,
  output logic [DW-1:0]     ramWd,
  output logic [DW-1:0]     xReg,
  output logic [DW-1:0]     yReg,
  output logic [DW-1:0]     zReg,
  output logic              carry,
  output logic              zIsZero
);

  localparam int AW = 2 * DW;

  logic [AW-1:0] loc;
  logic          useFlag;
  logic [DW-1:0] aluRes;
  logic          aluCout;
  logic [DW-1:0] wrData;

  nib_alu #(.DW(DW)) u_alu (
    .opA   (xReg),
    .opB   (yReg),
    .cin   (carry & useFlag),
    .doSub (strb.aluSub),
    .res   (aluRes),
    .cout  (aluCout)
  );

  always_comb begin
    case (strb.src)
      SRC_IMM: wrData = imm;
      SRC_RAM: wrData = ramRd;
      default: wrData = aluRes;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xReg    <= '0;
      yReg    <= '0;
      zReg    <= '0;
      carry   <= 1'b0;
      useFlag <= 1'b0;
      loc     <= '0;
    end else begin
      if (strb.wrX) xReg <= wrData;
      if (strb.wrY) yReg <= wrData;
      if (strb.wrZ) zReg <= wrData;
      if (strb.aluGo) begin
        carry   <= aluCout;
        useFlag <= 1'b0;
      end else if (strb.useTgl) begin
        useFlag <= ~useFlag;
      end
      if (strb.locHi) loc[AW-1:DW] <= imm;
      if (strb.locLo) loc[DW-1:0]  <= imm;
    end
  end

  assign ramAddr = loc;
  assign ramWe   = strb.ramWr;
  assign ramWd   = zReg;
  assign zIsZero = (zReg == '0);

endmodule

// File: rtl/nib_core.sv
module nib_core
  import nib_pkg::*;
#(
  parameter int DW         = 4,
  parameter int FRAME_ROWS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     loadEn,
  input  logic [2*DW-1:0]          loadAddr,
  input  logic [OP_W+DW-1:0]       loadWord,
  output logic [2*DW-1:0]          pcOut,
  output logic [DW-1:0]            xOut,
  output logic [DW-1:0]            yOut,
  output logic [DW-1:0]            zOut,
  output logic                     carryOut,
  output logic [FRAME_ROWS*DW-1:0] frameOut
);

  localparam int AW    = 2 * DW;
  localparam int IW    = OP_W + DW;
  localparam int DEPTH = 1 << AW;

  strobe_t       strb;
  logic [DW-1:0] imm;
  logic [DW-1:0] ramRd;
  logic [DW-1:0] ramWd;
  logic [AW-1:0] ramAddr;
  logic          ramWe;
  logic          zIsZero;
  logic [AW-1:0] pc;
  logic [IW-1:0] instrWord;

  logic [IW-1:0] romMem [DEPTH];
  logic [DW-1:0] ramMem [DEPTH];

  always_ff @(posedge clk) begin
    if (loadEn) romMem[loadAddr] <= loadWord;
  end

  always_ff @(posedge clk) begin
    if (ramWe) ramMem[ramAddr] <= ramWd;
  end

  assign instrWord = romMem[pc];
  assign ramRd     = ramMem[ramAddr];

  nib_ctrl #(.DW(DW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrWord (instrWord),
    .zIsZero   (zIsZero),
    .strb      (strb),
    .imm       (imm),
    .pc        (pc)
  );

  nib_dpath #(.DW(DW)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .imm     (imm),
    .ramRd   (ramRd),
    .ramAddr (ramAddr),
    .ramWe   (ramWe),
    .ramWd   (ramWd),
    .xReg    (xOut),
    .yReg    (yOut),
    .zReg    (zOut),
    .carry   (carryOut),
    .zIsZero (zIsZero)
  );

  for (genvar r = 0; r < FRAME_ROWS; r++) begin : g_row
    assign frameOut[r*DW +: DW] = ramMem[r];
  end

  assign pcOut = pc;

endmodule

// File: rtl/nib_core_chk.sv
module nib_core_chk
  import nib_pkg::*;
#(
  parameter int DW = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [OP_W+DW-1:0]  instrWord,
  input logic [2*DW-1:0]     pcOut,
  input logic [DW-1:0]       xOut,
  input logic [DW-1:0]       yOut,
  input logic [DW-1:0]       zOut,
  input logic                carryOut
);

  localparam int AW = 2 * DW;
  localparam int IW = OP_W + DW;

  logic          primed;
  opcode_e       op;
  logic [DW-1:0] sumW;
  logic [DW-1:0] diffW;

  assign op    = opcode_e'(instrWord[IW-1:DW]);
  assign sumW  = xOut + yOut;
  assign diffW = xOut - yOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  assert_first_cycle_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !primed |=> (pcOut == AW'(1) && xOut == '0 && yOut == '0 && zOut == '0 && !carryOut));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (primed && op != OP_JZ) |=> (pcOut == $past(pcOut) + AW'(1)));

  assert_nop_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (primed && op == OP_NOP) |=>
      ($stable(xOut) && $stable(yOut) && $stable(zOut) && $stable(carryOut)));

  assert_setx_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (primed && op == OP_SETX) |=> (xOut == $past(instrWord[DW-1:0])));

  assert_add_result_R5: assert property (@(posedge clk) disable iff (!rstN)
    (primed && op == OP_ADD) |=>
      (zOut == $past(sumW) || zOut == $past(sumW) + DW'(1)));

  assert_sub_result_R6: assert property (@(posedge clk) disable iff (!rstN)
    (primed && op == OP_SUB) |=>
      (zOut == $past(diffW) || zOut == $past(diffW) - DW'(1)));

  assert_jz_fallthrough_R9: assert property (@(posedge clk) disable iff (!rstN)
    (primed && op == OP_JZ && zOut != '0) |=> (pcOut == $past(pcOut) + AW'(1)));

endmodule

bind nib_core nib_core_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instrWord (instrWord),
  .pcOut     (pcOut),
  .xOut      (xOut),
  .yOut      (yOut),
  .zOut      (zOut),
  .carryOut  (carryOut)
);

// File: tb/nib_core_tb.sv
module nib_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 4;
  localparam int AW         = 2 * DW;
  localparam int IW         = 4 + DW;
  localparam int DEPTH      = 1 << AW;
  localparam int WD_LIMIT   = 20000;

  localparam int S_PC = 0;
  localparam int S_X  = 1;
  localparam int S_Y  = 2;
  localparam int S_Z  = 3;
  localparam int S_C  = 4;
  localparam int S_F  = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              loadEn = 1'b0;
  logic [AW-1:0]     loadAddr = '0;
  logic [IW-1:0]     loadWord = '0;
  logic [AW-1:0]     pcOut;
  logic [DW-1:0]     xOut;
  logic [DW-1:0]     yOut;
  logic [DW-1:0]     zOut;
  logic              carryOut;
  logic [4*DW-1:0]   frameOut;

  typedef struct {
    int    cyc;
    int    sel;
    int    val;
    string tag;
  } item_t;

  item_t       sbq[$];
  item_t       it;
  logic [IW-1:0] prog [DEPTH];
  int          checks = 0;
  int          failures = 0;
  int          edges = 0;
  int          wd = 0;
  logic        armed = 1'b0;

  nib_core u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadWord (loadWord),
    .pcOut    (pcOut),
    .xOut     (xOut),
    .yOut     (yOut),
    .zOut     (zOut),
    .carryOut (carryOut),
    .frameOut (frameOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) edges <= 0;
    else       edges <= edges + 1;
  end

  function automatic int pick(int sel);
    case (sel)
      S_PC:    return int'(pcOut);
      S_X:     return int'(xOut);
      S_Y:     return int'(yOut);
      S_Z:     return int'(zOut);
      S_C:     return int'(carryOut);
      default: return int'(frameOut);
    endcase
  endfunction

  // monitor: pop expected items whose cycle has come and compare
  always @(negedge clk) begin
    if (armed) begin
      while (sbq.size() > 0 && sbq[0].cyc <= edges) begin
        it = sbq.pop_front();
        checks++;
        if (it.cyc < edges) begin
          failures++;
          $display("FAIL %s missed cyc=%0d sel=%0d actual=none expected=%0h",
                   it.tag, it.cyc, it.sel, it.val);
        end else if (pick(it.sel) != it.val) begin
          failures++;
          $display("FAIL %s cyc=%0d sel=%0d actual=%0h expected=%0h",
                   it.tag, it.cyc, it.sel, pick(it.sel), it.val);
        end
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", wd, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic expectAt(int cyc, int sel, int val, string tag);
    item_t e;
    e.cyc = cyc;
    e.sel = sel;
    e.val = val;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic clearProg();
    for (int a = 0; a < DEPTH; a++) prog[a] = '0;
  endtask

  // R11: the program store is written through the load port
  task automatic burnRom();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      loadEn   = 1'b1;
      loadAddr = AW'(a);
      loadWord = prog[a];
    end
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic runProg(int nCycles);
    armed = 1'b1;
    @(negedge clk);
    #(CLK_PERIOD/4);
    rstN = 1'b1;
    repeat (nCycles) @(negedge clk);
    #1;
    if (sbq.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sbq.size());
      sbq.delete();
    end
    armed = 1'b0;
    rstN  = 1'b0;
  endtask

  initial begin
    // ---------- arithmetic, carry option, first-cycle skip ----------
    clearProg();
    prog[0]  = 8'h5F; prog[1]  = 8'h59; prog[2]  = 8'h68; prog[3]  = 8'h10;
    prog[4]  = 8'h00; prog[5]  = 8'h20; prog[6]  = 8'h53; prog[7]  = 8'h20;
    prog[8]  = 8'hF0; prog[9]  = 8'h10; prog[10] = 8'h10; prog[11] = 8'h6F;
    prog[12] = 8'h10; prog[13] = 8'hF0; prog[14] = 8'h00; prog[15] = 8'h20;
    prog[16] = 8'hF0; prog[17] = 8'hF0; prog[18] = 8'h10;
    burnRom();
    expectAt(0,  S_PC, 0,  "R1 reset pc");
    expectAt(0,  S_X,  0,  "R1 reset x");
    expectAt(0,  S_Z,  0,  "R1 reset z");
    expectAt(0,  S_C,  0,  "R1 reset carry");
    expectAt(1,  S_PC, 1,  "R1 first cycle pc");
    expectAt(1,  S_X,  0,  "R1 word0 skipped");
    expectAt(2,  S_X,  9,  "R4 setx");
    expectAt(3,  S_Y,  8,  "R4 sety");
    expectAt(4,  S_Z,  1,  "R5 add wrap");
    expectAt(4,  S_C,  1,  "R5 add carry");
    expectAt(5,  S_PC, 5,  "R3 nop pc");
    expectAt(5,  S_X,  9,  "R3 nop x");
    expectAt(5,  S_Z,  1,  "R3 nop z");
    expectAt(5,  S_C,  1,  "R3 nop carry");
    expectAt(6,  S_Z,  1,  "R6 sub");
    expectAt(6,  S_C,  0,  "R6 sub no borrow");
    expectAt(8,  S_Z,  11, "R6 sub wrap");
    expectAt(8,  S_C,  1,  "R6 sub borrow");
    expectAt(10, S_Z,  12, "R7 add with carry-in");
    expectAt(10, S_C,  0,  "R7 add with carry-in flag");
    expectAt(11, S_Z,  11, "R7 option cleared");
    expectAt(13, S_Z,  2,  "R5 add 3+15");
    expectAt(13, S_C,  1,  "R5 add 3+15 carry");
    expectAt(16, S_Z,  3,  "R7 sub with borrow-in across nop");
    expectAt(16, S_C,  1,  "R7 sub borrow-in flag");
    expectAt(19, S_Z,  2,  "R7 double toggle cancels");
    expectAt(19, S_C,  1,  "R7 double toggle carry");
    expectAt(19, S_PC, 19, "R2 sequential pc");
    runProg(19);

    // ---------- location pointer, data memory, frame ----------
    clearProg();
    prog[1]  = 8'h30; prog[2]  = 8'h40; prog[3]  = 8'h7A; prog[4]  = 8'h80;
    prog[5]  = 8'h41; prog[6]  = 8'h75; prog[7]  = 8'h80;
    prog[8]  = 8'h42; prog[9]  = 8'h7C; prog[10] = 8'h80;
    prog[11] = 8'h43; prog[12] = 8'h73; prog[13] = 8'h80;
    prog[14] = 8'h3B; prog[15] = 8'h47; prog[16] = 8'h76; prog[17] = 8'h80;
    prog[18] = 8'h70; prog[19] = 8'hD0; prog[20] = 8'h30; prog[21] = 8'h42;
    prog[22] = 8'hE0; prog[23] = 8'h90;
    burnRom();
    expectAt(14, S_F, 16'h3C5A, "R10 frame rows");
    expectAt(18, S_F, 16'h3C5A, "R8 upper pointer nibble honoured");
    expectAt(20, S_X, 6,        "R8 ldx from 0xB7");
    expectAt(23, S_Y, 12,       "R8 ldy from row 2");
    expectAt(24, S_Z, 12,       "R8 ldz from row 2");
    runProg(24);

    // ---------- branch target, conditional jump, wrap ----------
    clearProg();
    prog[0]   = 8'h5D; prog[1]  = 8'hA0; prog[2]  = 8'hB8; prog[3]  = 8'h71;
    prog[4]   = 8'hC0; prog[5]  = 8'h70; prog[6]  = 8'hC0; prog[7]  = 8'h5F;
    prog[8]   = 8'h54; prog[9]  = 8'hAF; prog[10] = 8'hBE; prog[11] = 8'hC0;
    prog[254] = 8'h67; prog[255] = 8'h52;
    burnRom();
    expectAt(1,  S_X,  0,    "R1 word0 skipped again");
    expectAt(5,  S_PC, 5,    "R9 jz falls through");
    expectAt(7,  S_PC, 8,    "R9 jz taken");
    expectAt(7,  S_X,  0,    "R9 target skips word 7");
    expectAt(8,  S_X,  4,    "R9 runs at target");
    expectAt(11, S_PC, 254,  "R9 jz to high target");
    expectAt(12, S_Y,  7,    "R4 sety at 254");
    expectAt(13, S_PC, 0,    "R2 pc wraps");
    expectAt(13, S_X,  2,    "R4 setx at 255");
    expectAt(14, S_X,  13,   "R11 loaded word0 executes after wrap");
    expectAt(14, S_PC, 1,    "R2 pc after word0");
    runProg(14);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule